// File: doc/BRIEF.md
# Command-Driven Activity Log

This block records activity into an on-chip log memory and hands it back through one register port. The same write data path carries command codes (turn logging on or off, empty the log, switch clear-on-readout, pick stop-when-full or overwrite-oldest behaviour, and steer reads toward either the log words or a status word). Reads return one word per read strobe, one cycle later.

A build-time parameter selects the recording variant. The event variant stores one entry per accepted event: a timestamp word followed by a parameterised number of data words. The timestamp counts clock cycles since reset release. The periodic variant stores one sample word each time a programmable interval of cycles elapses. Producers of the events and samples live outside the block.

When clear-on-readout is active, the log empties in the same cycle as the read that returns its last valid word. A word written in that cycle survives as the first word of the fresh log, so an agent draining the log loses nothing between its last read and the clear.

Top module: `activity_log`

## Requirements
- R1: After reset the status word reads 0 (logging off, clear-on-readout off, no overflow, fill 0), stop-when-full mode and status readout are selected, and reg_rdata is 0.
- R2: A write of 0x01 turns logging on and 0x00 turns it off; while off, no new event or sample is accepted and the fill amount does not change.
- R3: A write of 0x02 empties the log: the fill amount and the overflow flag return to 0 and later log reads return 0.
- R4: A write of 0x04 turns clear-on-readout on and 0x03 turns it off, visible in status bit 1.
- R5: A write of 0x07 selects log readout and restarts it at the oldest stored word; 0x08 selects status readout. Status reads do not move the readout position.
- R6: The status word carries logging-on in bit 0, clear-on-readout in bit 1, overflow in bit 2, the fill amount in words in bits 10..3, and zeros in bits 31..11.
- R7: In the event variant an entry is a timestamp word (cycles since reset release, sampled in the accepting cycle) followed by the data words, lowest data word first; ev_ready is low while an entry is being stored, one word per cycle.
- R8: In stop-when-full mode (0x05) words arriving with the log full are dropped, the stored words and the fill amount stay unchanged, and overflow is set.
- R9: In overwrite-oldest mode (0x06) a word arriving with the log full replaces the oldest word, the fill amount stays at full, overflow is set, and readout starts at the oldest remaining word.
- R10: Log reads return stored words in arrival order and return 0 once the readout position reaches the fill amount; without clear-on-readout, reading does not change the fill amount.
- R11: With clear-on-readout on, the read returning the last valid word empties the log and clears overflow; a word stored in that same cycle remains as the only entry.
- R12: In the periodic variant one smp_data word is stored every smp_interval cycles while logging is on; an interval of 0 acts as 1.
- R13: A write of any other value, including one with bits above bit 7 set, changes no state.
- R14: reg_rdata changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Command write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Command code |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| ev_valid | input | 1 | Event offered (event variant) |
| ev_data | input | max(1, EVT_DATA_WORDS*DATA_W) | Event data words, word 0 in the low bits |
| ev_ready | output | 1 | Event can be accepted (always 0 in the periodic variant) |
| smp_data | input | DATA_W | Sample value (periodic variant) |
| smp_interval | input | INTV_W | Sampling interval in cycles (periodic variant) |

## Verification
The collision that matters is the readout of the last valid word landing in the same cycle as a new word being stored. The bench launches a two-word event and sweeps the final read to the cycle before the first stored word, onto the timestamp word, and onto the data word. In the first two positions the log must end holding exactly the new entry; in the third the read is no longer final, so nothing clears and all four words remain, which the bench confirms through the status fill amount and a full readout.

// File: rtl/actlog_pkg.sv
package actlog_pkg;

   typedef enum logic [7:0] {
      CMD_LOG_OFF     = 8'h00,
      CMD_LOG_ON      = 8'h01,
      CMD_WIPE        = 8'h02,
      CMD_ACLR_OFF    = 8'h03,
      CMD_ACLR_ON     = 8'h04,
      CMD_MODE_STOP   = 8'h05,
      CMD_MODE_RING   = 8'h06,
      CMD_SEL_LOG     = 8'h07,
      CMD_SEL_STATUS  = 8'h08
   } actlog_cmd_e;

   localparam int STAT_EN_BIT   = 0;
   localparam int STAT_ACLR_BIT = 1;
   localparam int STAT_OVF_BIT  = 2;
   localparam int STAT_FILL_LSB = 3;
   localparam int STAT_FILL_MAX = 8;

   typedef enum logic {
      KIND_EVENT    = 1'b0,
      KIND_PERIODIC = 1'b1
   } actlog_kind_e;

endpackage

// File: rtl/actlog_cmd.sv
module actlog_cmd
   import actlog_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              log_on,
   output logic              aclr_on,
   output logic              ring_on,
   output logic              sel_log,
   output logic              wipe_p,
   output logic              restart_p
);

   logic       code_ok;
   logic [7:0] code;

   assign code_ok = wr && (wdata[DATA_W-1:8] == '0);
   assign code    = wdata[7:0];

   always_comb begin
      wipe_p    = code_ok && (code == CMD_WIPE);
      restart_p = code_ok && (code == CMD_SEL_LOG);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_on  <= 1'b0;
         aclr_on <= 1'b0;
         ring_on <= 1'b0;
         sel_log <= 1'b0;
      end else if (code_ok) begin
         case (code)
            CMD_LOG_OFF:    log_on  <= 1'b0;
            CMD_LOG_ON:     log_on  <= 1'b1;
            CMD_ACLR_OFF:   aclr_on <= 1'b0;
            CMD_ACLR_ON:    aclr_on <= 1'b1;
            CMD_MODE_STOP:  ring_on <= 1'b0;
            CMD_MODE_RING:  ring_on <= 1'b1;
            CMD_SEL_LOG:    sel_log <= 1'b1;
            CMD_SEL_STATUS: sel_log <= 1'b0;
            default: ;
         endcase
      end
   end

   // R2: enable command takes effect on the next cycle
   a_r2_log_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata == DATA_W'(1)) |=> log_on);

   // R13: out-of-range command leaves every mode bit untouched
   a_r13_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata > DATA_W'(8)) |=> $stable({log_on, aclr_on, ring_on, sel_log}));

endmodule

// File: rtl/actlog_evsrc.sv
module actlog_evsrc #(
   parameter int DATA_W = 32,
   parameter int DWORDS = 1,
   parameter int BUS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              log_on,
   input  logic              ev_valid,
   input  logic [BUS_W-1:0]  ev_data,
   output logic              ev_ready,
   output logic              wr_vld,
   output logic [DATA_W-1:0] wr_word
);

   localparam int ENTRY_W = 1 + DWORDS;
   localparam int CNT_W   = $clog2(ENTRY_W + 1);

   logic [DATA_W-1:0]               stamp;
   logic [ENTRY_W-1:0][DATA_W-1:0]  load_v;
   logic [ENTRY_W-1:0][DATA_W-1:0]  sh;
   logic [CNT_W-1:0]                left;
   logic                            take;

   assign load_v[0] = stamp;

   generate
      if (DWORDS > 0) begin : g_data
         for (genvar g = 0; g < DWORDS; g++) begin : g_word
            assign load_v[g+1] = ev_data[g*DATA_W +: DATA_W];
         end
      end else begin : g_nodata
         logic unused_ev_data;
         assign unused_ev_data = ^ev_data;
      end
   endgenerate

   assign ev_ready = (left == '0);
   assign take     = ev_ready && ev_valid && log_on;
   assign wr_vld   = (left != '0);
   assign wr_word  = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp <= '0;
         sh    <= '0;
         left  <= '0;
      end else begin
         stamp <= stamp + 1'b1;
         if (take) begin
            sh   <= load_v;
            left <= CNT_W'(ENTRY_W);
         end else if (left != '0) begin
            for (int k = 0; k < ENTRY_W - 1; k++) sh[k] <= sh[k+1];
            left <= left - 1'b1;
         end
      end
   end

   // R7: a stored run of words begins only after an accepted event
   a_r7_entry_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_vld) |-> $past(ev_valid && log_on));

   // R7: no acceptance while an entry is still being stored
   a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready && log_on) |=> !ev_ready);

endmodule

// File: rtl/actlog_pdsrc.sv
module actlog_pdsrc #(
   parameter int DATA_W = 32,
   parameter int INTV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              log_on,
   input  logic [INTV_W-1:0] interval,
   input  logic [DATA_W-1:0] sample,
   output logic              wr_vld,
   output logic [DATA_W-1:0] wr_word
);

   logic [INTV_W-1:0] tick;
   logic [INTV_W-1:0] last;

   assign last    = (interval == '0) ? '0 : interval - 1'b1;
   assign wr_vld  = log_on && (tick >= last);
   assign wr_word = sample;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             tick <= '0;
      else if (!log_on)       tick <= '0;
      else if (tick >= last)  tick <= '0;
      else                    tick <= tick + 1'b1;
   end

   // R12: back-to-back samples only with an interval of one cycle or less
   a_r12_sample_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld |=> (interval <= INTV_W'(1)) || !wr_vld);

endmodule

// File: rtl/actlog_store.sv
module actlog_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 128
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_vld,
   input  logic [DATA_W-1:0]           wr_word,
   input  logic                        ring_on,
   input  logic                        aclr_on,
   input  logic                        wipe_cmd,
   input  logic                        restart,
   input  logic                        rd_take,
   output logic [DATA_W-1:0]           rd_word,
   output logic [$clog2(DEPTH+1)-1:0]  fill,
   output logic                        ovf
);

   localparam int AW     = $clog2(DEPTH);
   localparam int FILL_W = $clog2(DEPTH + 1);
   localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     head;
   logic [AW-1:0]     wpos;
   logic [AW-1:0]     rpos;
   logic [FILL_W-1:0] rd_idx;
   logic [FILL_W-1:0] rd_nxt;
   logic              has_rd, last_rd, wipe, full, adv, evict, store_en;

   always_comb begin
      full     = (fill == FULL_CNT);
      has_rd   = (rd_idx < fill);
      adv      = rd_take && has_rd;
      last_rd  = adv && (FILL_W'(rd_idx + 1'b1) == fill);
      wipe     = wipe_cmd || (aclr_on && last_rd);
      evict    = wr_vld && full && ring_on && !wipe;
      store_en = wr_vld && (wipe || !full || ring_on);
      wpos     = wipe ? '0 : AW'(head + fill[AW-1:0]);
      rpos     = AW'(head + rd_idx[AW-1:0]);
      rd_word  = has_rd ? mem[rpos] : '0;
      rd_nxt   = rd_idx;
      if (adv)                    rd_nxt = rd_nxt + 1'b1;
      if (evict && rd_nxt != '0)  rd_nxt = rd_nxt - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (store_en) mem[wpos] <= wr_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head   <= '0;
         fill   <= '0;
         rd_idx <= '0;
         ovf    <= 1'b0;
      end else if (wipe) begin
         head   <= '0;
         fill   <= wr_vld ? FILL_W'(1) : '0;
         rd_idx <= '0;
         ovf    <= 1'b0;
      end else begin
         if (wr_vld) begin
            if (!full) begin
               fill <= fill + 1'b1;
            end else begin
               ovf <= 1'b1;
               if (ring_on) head <= head + 1'b1;
            end
         end
         rd_idx <= restart ? '0 : rd_nxt;
      end
   end

   // R8: the fill amount never exceeds the memory depth
   a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_CNT);

   // R10: readout position never passes the fill amount
   a_r10_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rd_idx <= fill);

   // R3: emptying leaves at most the word stored alongside it, no overflow
   a_r3_wipe_empties: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (fill <= FILL_W'(1)) && !ovf);

   // R9: overwrite-oldest mode stays full once full
   a_r9_ring_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_on && full && !wipe) |=> full);

   // R8: stop-when-full mode freezes the stored window
   a_r8_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_on && full && !wipe) |=> (full && $stable(head)));

   // R11: a word arriving with the final read survives the clear
   a_r11_aclr_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
      (aclr_on && last_rd && !wipe_cmd && wr_vld) |=> fill == FILL_W'(1));

endmodule

// File: rtl/activity_log.sv
module activity_log
   import actlog_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int DEPTH          = 128,
   parameter int LOG_KIND       = 0,
   parameter int EVT_DATA_WORDS = 1,
   parameter int INTV_W         = 16,
   localparam int EV_BUS_W      = (EVT_DATA_WORDS > 0) ? EVT_DATA_WORDS * DATA_W : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                ev_valid,
   input  logic [EV_BUS_W-1:0] ev_data,
   output logic                ev_ready,
   input  logic [DATA_W-1:0]   smp_data,
   input  logic [INTV_W-1:0]   smp_interval
);

   localparam int FILL_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("activity_log: DEPTH must be a power of two, at least 2");
      end
      if (FILL_W > STAT_FILL_MAX) begin : g_bad_fill
         $error("activity_log: fill amount does not fit status bits 10..3");
      end
      if (DATA_W < 32) begin : g_bad_width
         $error("activity_log: DATA_W must be at least 32");
      end
      if (LOG_KIND != 0 && LOG_KIND != 1) begin : g_bad_kind
         $error("activity_log: LOG_KIND must be 0 (event) or 1 (periodic)");
      end
   endgenerate

   logic              log_on, aclr_on, ring_on, sel_log, wipe_p, restart_p;
   logic              wr_vld;
   logic [DATA_W-1:0] wr_word;
   logic [DATA_W-1:0] rd_word;
   logic [FILL_W-1:0] fill;
   logic              ovf;
   logic [DATA_W-1:0] status;

   actlog_cmd #(.DATA_W(DATA_W)) cmd_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .wdata     (reg_wdata),
      .log_on    (log_on),
      .aclr_on   (aclr_on),
      .ring_on   (ring_on),
      .sel_log   (sel_log),
      .wipe_p    (wipe_p),
      .restart_p (restart_p)
   );

   generate
      if (LOG_KIND == int'(KIND_EVENT)) begin : g_event
         actlog_evsrc #(.DATA_W(DATA_W), .DWORDS(EVT_DATA_WORDS), .BUS_W(EV_BUS_W)) src_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .log_on   (log_on),
            .ev_valid (ev_valid),
            .ev_data  (ev_data),
            .ev_ready (ev_ready),
            .wr_vld   (wr_vld),
            .wr_word  (wr_word)
         );
         logic unused_smp;
         assign unused_smp = ^{smp_data, smp_interval};
      end else begin : g_periodic
         actlog_pdsrc #(.DATA_W(DATA_W), .INTV_W(INTV_W)) src_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .log_on   (log_on),
            .interval (smp_interval),
            .sample   (smp_data),
            .wr_vld   (wr_vld),
            .wr_word  (wr_word)
         );
         assign ev_ready = 1'b0;
         logic unused_ev;
         assign unused_ev = ^{ev_valid, ev_data};
      end
   endgenerate

   actlog_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_vld   (wr_vld),
      .wr_word  (wr_word),
      .ring_on  (ring_on),
      .aclr_on  (aclr_on),
      .wipe_cmd (wipe_p),
      .restart  (restart_p),
      .rd_take  (reg_rd && sel_log),
      .rd_word  (rd_word),
      .fill     (fill),
      .ovf      (ovf)
   );

   always_comb begin
      status                             = '0;
      status[STAT_EN_BIT]                = log_on;
      status[STAT_ACLR_BIT]              = aclr_on;
      status[STAT_OVF_BIT]               = ovf;
      status[STAT_FILL_LSB +: FILL_W]    = fill;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= sel_log ? rd_word : status;
   end

   // R14: read data holds without a read strobe
   a_r14_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   // R6: status reads keep the upper bits at zero
   a_r6_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !sel_log) |=> (reg_rdata >> (STAT_FILL_LSB + FILL_W)) == '0);

endmodule

// File: tb/activity_log_tb_top.sv
`timescale 1ns/1ps
module activity_log_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tb_cyc;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tb_cyc <= '0;
      else        tb_cyc <= tb_cyc + 1'b1;
   end

   // event-variant instance, small depth
   logic        e_wr = 0, e_rd = 0, e_valid = 0, e_ready;
   logic [31:0] e_wdata = 0, e_rdata, e_data = 0;
   // periodic-variant instance
   logic        p_wr = 0, p_rd = 0, p_ready;
   logic [31:0] p_wdata = 0, p_rdata;
   logic [15:0] p_intv = 16'd3;

   activity_log #(.DEPTH(16), .LOG_KIND(0), .EVT_DATA_WORDS(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(e_wr), .reg_rd(e_rd), .reg_wdata(e_wdata),
      .reg_rdata(e_rdata), .ev_valid(e_valid), .ev_data(e_data), .ev_ready(e_ready),
      .smp_data(32'h0), .smp_interval(16'h0));

   activity_log #(.DEPTH(8), .LOG_KIND(1), .EVT_DATA_WORDS(1)) pd_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(p_wr), .reg_rd(p_rd), .reg_wdata(p_wdata),
      .reg_rdata(p_rdata), .ev_valid(1'b0), .ev_data(32'h0), .ev_ready(p_ready),
      .smp_data(tb_cyc), .smp_interval(p_intv));

   function automatic logic [31:0] stat(input int fill, input bit ovf, input bit acl, input bit en);
      return (32'(fill) << 3) | (32'(ovf) << 2) | (32'(acl) << 1) | 32'(en);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cmd(input bit pd, input logic [31:0] c);
      @(negedge clk);
      if (pd) begin p_wr = 1; p_wdata = c; end
      else    begin e_wr = 1; e_wdata = c; end
      @(negedge clk);
      p_wr = 0; e_wr = 0;
   endtask

   task automatic rd(input bit pd, output logic [31:0] v);
      @(negedge clk);
      if (pd) p_rd = 1; else e_rd = 1;
      @(negedge clk);
      p_rd = 0; e_rd = 0;
      v = pd ? p_rdata : e_rdata;
   endtask

   task automatic evt(input logic [31:0] d, output logic [31:0] ts);
      @(negedge clk);
      while (!e_ready) @(negedge clk);
      e_valid = 1; e_data = d; ts = tb_cyc;
      @(negedge clk);
      e_valid = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v, prev;
      logic [31:0] ts [20];
      logic [31:0] ts_a, ts_b;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      chk("R1 rdata after reset", e_rdata, 32'h0);
      rd(0, v); chk("R1 status after reset", v, 32'h0);

      cmd(0, 32'h9);   rd(0, v); chk("R13 code 0x09", v, 32'h0);
      cmd(0, 32'h101); rd(0, v); chk("R13 high bits set", v, 32'h0);

      cmd(0, 32'h4); rd(0, v); chk("R4 auto clear on", v, stat(0, 0, 1, 0));
      cmd(0, 32'h3); rd(0, v); chk("R4 auto clear off", v, stat(0, 0, 0, 0));

      evt(32'hDEAD_0001, ts_a);
      rd(0, v); chk("R2 no record while off", v, stat(0, 0, 0, 0));

      cmd(0, 32'h1); rd(0, v); chk("R2 logging on", v, stat(0, 0, 0, 1));
      for (int i = 0; i < 3; i++) evt(32'hA000_0000 + 32'(i), ts[i]);
      rd(0, v); chk("R6 status fill 6", v, stat(6, 0, 0, 1));

      cmd(0, 32'h7);
      for (int i = 0; i < 3; i++) begin
         rd(0, v); chk("R7 timestamp word", v, ts[i]);
         rd(0, v); chk("R7 data word", v, 32'hA000_0000 + 32'(i));
      end
      rd(0, v); chk("R10 read past fill", v, 32'h0);
      rd(0, v); chk("R10 read past fill again", v, 32'h0);
      cmd(0, 32'h8); rd(0, v); chk("R10 fill unchanged by reads", v, stat(6, 0, 0, 1));
      rd(0, v); chk("R5 status read repeat", v, stat(6, 0, 0, 1));

      cmd(0, 32'h7); rd(0, v); chk("R5 restart at oldest", v, ts[0]);

      cmd(0, 32'h2); cmd(0, 32'h8); rd(0, v); chk("R3 clear status", v, stat(0, 0, 0, 1));
      cmd(0, 32'h7); rd(0, v); chk("R3 cleared read", v, 32'h0);

      // stop-when-full: 9 two-word events into 16 words
      cmd(0, 32'h5);
      for (int i = 0; i < 9; i++) evt(32'hB000_0000 + 32'(i), ts[i]);
      cmd(0, 32'h8); rd(0, v); chk("R8 full with overflow", v, stat(16, 1, 0, 1));
      cmd(0, 32'h7);
      for (int i = 0; i < 8; i++) begin
         rd(0, v); chk("R8 kept timestamp", v, ts[i]);
         rd(0, v); chk("R8 kept data", v, 32'hB000_0000 + 32'(i));
      end
      rd(0, v); chk("R8 dropped event absent", v, 32'h0);

      prev = e_rdata;
      repeat (5) @(negedge clk);
      chk("R14 hold while idle", e_rdata, prev);
      cmd(0, 32'h8);
      chk("R14 hold across command", e_rdata, prev);

      // overwrite-oldest: 10 events, oldest 2 replaced
      cmd(0, 32'h2); cmd(0, 32'h6);
      for (int i = 0; i < 10; i++) evt(32'hC000_0000 + 32'(i), ts[i]);
      rd(0, v); chk("R9 full with overflow", v, stat(16, 1, 0, 1));
      cmd(0, 32'h7);
      for (int i = 2; i < 10; i++) begin
         rd(0, v); chk("R9 oldest-first timestamp", v, ts[i]);
         rd(0, v); chk("R9 oldest-first data", v, 32'hC000_0000 + 32'(i));
      end
      rd(0, v); chk("R10 ring read past fill", v, 32'h0);

      // clear-on-readout, final read swept against a new entry
      cmd(0, 32'h4);
      for (int k = 0; k < 3; k++) begin
         cmd(0, 32'h2);
         evt(32'hD000_0000 + 32'(k), ts_a);
         cmd(0, 32'h7);
         rd(0, v); chk("R11 first word", v, ts_a);
         for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            e_valid = (t == 0);
            e_data  = 32'hE000_0000 + 32'(k);
            if (t == 0) ts_b = tb_cyc;
            e_rd    = (t == k);
         end
         @(negedge clk);
         e_valid = 0; e_rd = 0;
         chk("R11 final read data", e_rdata, 32'hD000_0000 + 32'(k));
         cmd(0, 32'h8); rd(0, v);
         if (k < 2) begin
            chk("R11 cleared, new entry kept", v, stat(2, 0, 1, 1));
            cmd(0, 32'h7);
            rd(0, v); chk("R11 kept timestamp", v, ts_b);
            rd(0, v); chk("R11 kept data", v, 32'hE000_0000 + 32'(k));
         end else begin
            chk("R11 not final, no clear", v, stat(4, 0, 1, 1));
            cmd(0, 32'h7);
            rd(0, v); chk("R11 old timestamp", v, ts_a);
            rd(0, v); chk("R11 old data", v, 32'hD000_0000 + 32'(k));
            rd(0, v); chk("R11 new timestamp", v, ts_b);
            rd(0, v); chk("R11 new data", v, 32'hE000_0000 + 32'(k));
         end
         cmd(0, 32'h8); rd(0, v); chk("R11 emptied after full read", v, stat(0, 0, 1, 1));
      end

      // periodic variant
      cmd(1, 32'h1);
      repeat (40) @(negedge clk);
      rd(1, v); chk("R12 periodic full", v, stat(8, 1, 0, 1));
      cmd(1, 32'h7);
      rd(1, prev);
      for (int i = 1; i < 8; i++) begin
         rd(1, v); chk("R12 interval 3 spacing", v - prev, 32'd3);
         prev = v;
      end
      cmd(1, 32'h0); p_intv = 16'd0; cmd(1, 32'h2); cmd(1, 32'h7); cmd(1, 32'h1);
      repeat (3) @(negedge clk);
      cmd(1, 32'h0);
      rd(1, prev);
      for (int i = 1; i < 4; i++) begin
         rd(1, v); chk("R12 interval 0 acts as 1", v - prev, 32'd1);
         prev = v;
      end
      rd(1, v); rd(1, v);
      cmd(1, 32'h8); rd(1, v);
      chk("R2 periodic off keeps fill", v, stat(5, 0, 0, 0));
      repeat (6) @(negedge clk);
      rd(1, v); chk("R2 periodic off no samples", v, stat(5, 0, 0, 0));

      done = 1;
      summary();
      $finish;
   end

endmodule